// File: doc/BRIEF.md
# Zero-Run Literal Stream Expander

This block turns a compact byte stream back into the byte stream it was built from. The compact stream is a series of one-byte headers. A header with its top bit clear stands for a run of zero bytes, and its value gives the length of that run. A header with its top bit set announces a block of bytes that follows it and is passed through unchanged; the low seven bits give the length of that block. The two header values whose low seven bits are zero do nothing. An encoder may use them as padding.

Both the compact input and the expanded output are byte streams with a valid/ready handshake, and either side may stall. A zero run is produced at one byte per cycle, and the input is held off while it runs. A literal block is passed through combinationally, so it also moves at one byte per cycle. An input byte flagged as the end of a frame makes the block pulse a completion output once every byte that frame owes has left the output. If the frame ends in the middle of a literal block, a sticky error flag is set.

Top module: `zrl_expander`

## Requirements
- R1: A header byte of value v in 1..127 makes the output present exactly v bytes of value 0x00, one per accepted output cycle. While those bytes are owed, in_ready stays low.
- R2: A header byte of value v in 129..255 makes the next v−128 input bytes appear on the output unchanged and in the same order.
- R3: Header values 0x00 and 0x80 are accepted and produce no output. While a header is awaited, in_ready is high and out_valid is low.
- R4: The input byte after the final byte of a literal block, or after any header that starts a zero run, is decoded as a header.
- R5: Inside a literal block, in_ready equals out_ready and out_valid equals in_valid. With both sides ready, one byte moves every cycle with no idle cycle.
- R6: Output backpressure loses no byte and repeats no byte. While out_ready is low, the count of owed bytes and the decoder state do not change.
- R7: After an input byte with in_last set has been accepted, frame_done goes high for one cycle once the block is back to awaiting a header.
- R8: If in_last arrives on a literal header or on a literal byte that is not the block's final byte, lit_error becomes 1 and stays 1 until reset. The block then drops the rest of that block and awaits a header.
- R9: While rst is high and in the cycle after it falls: in_ready is 1, and out_valid, frame_done and lit_error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Compact stream byte |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | in_data is the final byte of a frame |
| in_ready | output | 1 | Block accepts in_data this cycle |
| out_data | output | 8 | Expanded byte |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Consumer takes out_data this cycle |
| frame_done | output | 1 | One-cycle pulse when a flagged frame has fully drained |
| lit_error | output | 1 | Sticky flag: frame ended inside a literal block |

## Verification
Random frames mix long zero stretches (more than 127, so that runs must split) with dense non-zero stretches (longer than 127, so that literal blocks must split). Their encodings have pad headers scattered through them, and they run with random output stalls and input gaps. A lost, repeated or reordered byte therefore shows up as a mismatch against the original data. Directed frames hold both sides ready to isolate cycle timing: a single run shows in_ready held low for exactly the run length, and a literal block shows a byte on every cycle. Pad-only frames, maximal run and literal headers, and frames truncated on a literal header or mid-block separate no-op handling, length boundaries and the error path from normal decoding.

// File: rtl/zrl_pkg.sv
package zrl_pkg;

    localparam int BYTE_W = 8;
    localparam int LEN_W  = BYTE_W - 1;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_ZERO = 2'd1,
        ST_LIT  = 2'd2
    } zrl_state_e;

    typedef enum logic [1:0] {
        HK_NOP = 2'd0,
        HK_RUN = 2'd1,
        HK_LIT = 2'd2
    } hdr_kind_e;

    typedef struct packed {
        hdr_kind_e        kind;
        logic [LEN_W-1:0] len;
    } hdr_t;

    function automatic hdr_t decode_hdr(input logic [BYTE_W-1:0] b);
        hdr_t h;
        h.len = b[LEN_W-1:0];
        if (h.len == '0)
            h.kind = HK_NOP;
        else if (b[BYTE_W-1])
            h.kind = HK_LIT;
        else
            h.kind = HK_RUN;
        return h;
    endfunction

endpackage

// File: rtl/zrl_hdr_decode.sv
module zrl_hdr_decode
    import zrl_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output hdr_t              hdr_o
);
    always_comb hdr_o = decode_hdr(byte_i);
endmodule

// File: rtl/zrl_len_counter.sv
module zrl_len_counter
    import zrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    input  logic             clr,
    output logic [LEN_W-1:0] cnt,
    output logic             at_one
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - ONE;
    end

    assign at_one = (cnt == ONE);
endmodule

// File: rtl/zrl_frame_track.sv
module zrl_frame_track (
    input  logic clk,
    input  logic rst,
    input  logic last_taken,
    input  logic idle,
    input  logic abort,
    output logic frame_done,
    output logic lit_error
);
    logic pend_q;

    assign frame_done = pend_q && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            lit_error <= 1'b0;
        end else begin
            if (last_taken)
                pend_q <= 1'b1;
            else if (frame_done)
                pend_q <= 1'b0;
            if (abort)
                lit_error <= 1'b1;
        end
    end
endmodule

// File: rtl/zrl_expander.sv
module zrl_expander
    import zrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              frame_done,
    output logic              lit_error
);
    zrl_state_e       st_q, st_d;
    hdr_t             hdr;
    logic [LEN_W-1:0] cnt;
    logic             cnt_at_one;
    logic             load, dec, abort;
    logic             in_fire, out_fire;

    zrl_hdr_decode u_dec (
        .byte_i (in_data),
        .hdr_o  (hdr)
    );

    zrl_len_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (hdr.len),
        .dec      (dec),
        .clr      (abort),
        .cnt      (cnt),
        .at_one   (cnt_at_one)
    );

    zrl_frame_track u_frm (
        .clk        (clk),
        .rst        (rst),
        .last_taken (in_fire && in_last),
        .idle       (st_q == ST_HDR),
        .abort      (abort),
        .frame_done (frame_done),
        .lit_error  (lit_error)
    );

    // handshake steering per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        unique case (st_q)
            ST_HDR:  in_ready = 1'b1;
            ST_ZERO: out_valid = 1'b1;
            ST_LIT: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
            end
            default: ;
        endcase
    end

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // next-state and counter control
    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        dec   = 1'b0;
        abort = 1'b0;
        unique case (st_q)
            ST_HDR: begin
                if (in_fire) begin
                    unique case (hdr.kind)
                        HK_RUN: begin
                            st_d = ST_ZERO;
                            load = 1'b1;
                        end
                        HK_LIT: begin
                            if (in_last) begin
                                abort = 1'b1;
                            end else begin
                                st_d = ST_LIT;
                                load = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_ZERO: begin
                if (out_fire) begin
                    dec = 1'b1;
                    if (cnt_at_one)
                        st_d = ST_HDR;
                end
            end
            ST_LIT: begin
                if (in_fire) begin
                    if (cnt_at_one) begin
                        dec  = 1'b1;
                        st_d = ST_HDR;
                    end else if (in_last) begin
                        abort = 1'b1;
                        st_d  = ST_HDR;
                    end else begin
                        dec = 1'b1;
                    end
                end
            end
            default: st_d = ST_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ST_HDR;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/zrl_expander_chk.sv
module zrl_expander_chk
    import zrl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              frame_done,
    input logic              lit_error,
    input zrl_state_e        st,
    input logic [LEN_W-1:0]  cnt
);
    // R1: zero run shows zero bytes and blocks input
    a_r1_run_zero_blocks: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ZERO) |-> (out_valid && out_data == '0 && !in_ready));

    // R1: each taken zero byte lowers the count by one
    a_r1_run_count_step: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ZERO && out_ready && cnt > LEN_W'(1))
        |=> (st == ST_ZERO && cnt == $past(cnt) - LEN_W'(1)));

    // R3: waiting for a header produces nothing
    a_r3_hdr_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HDR) |-> (!out_valid && in_ready));

    // R5: literal flow tracks both sides
    a_r5_lit_flow: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LIT) |-> (in_ready == out_ready && out_valid == in_valid));

    // R6: output stall freezes progress
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (st != ST_HDR && !out_ready) |=> ($stable(cnt) && $stable(st)));

    // R6: an active mode always owes at least one byte
    a_r6_count_live: assert property (@(posedge clk) disable iff (rst)
        (st != ST_HDR) |-> (cnt != '0));

    // R7: completion only when idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (st == ST_HDR));

    // R8: error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        lit_error |=> lit_error);
endmodule

bind zrl_expander zrl_expander_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .frame_done (frame_done),
    .lit_error  (lit_error),
    .st         (st_q),
    .cnt        (cnt)
);

// File: tb/zrl_expander_tb_top.sv
module zrl_expander_tb_top;
    import zrl_pkg::*;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       frame_done;
    logic       lit_error;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  fd_count = 0;
    bit  rnd_mode = 1'b0;
    bit  finished = 1'b0;
    bq_t got;

    always #5 clk = ~clk;

    zrl_expander dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .frame_done (frame_done),
        .lit_error  (lit_error)
    );

    always @(posedge clk) begin
        #1 out_ready = rnd_mode ? (($urandom % 4) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) got.push_back(out_data);
            if (frame_done) fd_count++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit last);
        if (rnd_mode) begin
            repeat ($urandom % 3) begin
                @(posedge clk);
                #1;
            end
        end
        in_data  = b;
        in_last  = last;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_done(input int fd0);
        while (fd_count == fd0) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    function automatic bq_t encode(input bq_t d, input bit pads);
        bq_t c;
        int  i = 0;
        while (i < d.size()) begin
            if (pads && ($urandom % 8) == 0) c.push_back(($urandom % 2) ? 8'h80 : 8'h00);
            if (d[i] == 8'h00) begin
                int z = 0;
                while (i + z < d.size() && d[i+z] == 8'h00 && z < 127) z++;
                c.push_back(8'(z));
                i += z;
            end else begin
                int l = 0;
                while (i + l < d.size() && d[i+l] != 8'h00 && l < 127) l++;
                c.push_back(8'(128 + l));
                for (int k = 0; k < l; k++) c.push_back(d[i+k]);
                i += l;
            end
        end
        if (pads && ($urandom % 2) == 0) c.push_back(8'h80);
        return c;
    endfunction

    task automatic run_frame(input bq_t data, input bq_t stream, input string req);
        int fd0 = fd_count;
        int bad = 0;
        got.delete();
        for (int k = 0; k < stream.size(); k++)
            send_byte(stream[k], k == stream.size() - 1);
        wait_done(fd0);
        check(got.size() == data.size(), req, "output length", got.size(), data.size());
        for (int k = 0; k < data.size() && k < got.size(); k++)
            if (got[k] !== data[k]) bad++;
        check(bad == 0, req, "mismatched bytes", bad, 0);
        check(fd_count == fd0 + 1, "R7", "frame_done pulses", fd_count - fd0, 1);
    endtask

    function automatic bq_t rand_data();
        bq_t d;
        int  segs = 2 + $urandom % 6;
        for (int s = 0; s < segs; s++) begin
            int len = 1 + $urandom % 200;
            bit zero = ($urandom % 2) == 1;
            for (int k = 0; k < len; k++) begin
                if (zero) d.push_back(8'h00);
                else      d.push_back(8'(1 + $urandom % 255));
            end
        end
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

    initial begin
        bq_t d, s;
        void'($urandom(32'h5EED_0042));

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready && !out_valid && !frame_done && !lit_error, "R9",
              "reset outputs", {in_ready, out_valid, frame_done, lit_error}, 4'b1000);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(in_ready && !out_valid && !frame_done && !lit_error, "R9",
              "after reset", {in_ready, out_valid, frame_done, lit_error}, 4'b1000);
        @(posedge clk); #1;

        // R1: run of 10 with input offered, then a literal of one byte
        begin
            int fd0 = fd_count;
            int bad = 0;
            got.delete();
            send_byte(8'd10, 1'b0);
            in_data = 8'h81; in_valid = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (in_ready || !out_valid || out_data != 8'h00) bad++;
                @(posedge clk); #1;
            end
            check(bad == 0, "R1", "run cycles with input blocked", 10 - bad, 10);
            @(negedge clk);
            check(in_ready && !out_valid, "R4", "header awaited after run",
                  {in_ready, out_valid}, 2'b10);
            @(posedge clk); #1;
            in_valid = 1'b0;
            send_byte(8'h55, 1'b1);
            wait_done(fd0);
            d = {};
            repeat (10) d.push_back(8'h00);
            d.push_back(8'h55);
            check(got.size() == 11, "R1", "run output length", got.size(), 11);
            bad = 0;
            for (int k = 0; k < 11 && k < got.size(); k++) if (got[k] !== d[k]) bad++;
            check(bad == 0, "R2", "run then literal bytes", bad, 0);
        end

        // R5: literal of four bytes, no bubbles
        begin
            logic [7:0] v[4] = '{8'h12, 8'h00, 8'hA5, 8'hFF};
            int fd0 = fd_count;
            int bad = 0;
            got.delete();
            send_byte(8'h84, 1'b0);
            for (int k = 0; k < 4; k++) begin
                in_data = v[k]; in_valid = 1'b1; in_last = (k == 3);
                @(negedge clk);
                if (!in_ready || !out_valid || out_data != v[k]) bad++;
                @(posedge clk); #1;
            end
            in_valid = 1'b0; in_last = 1'b0;
            check(bad == 0, "R5", "literal cycles without bubble", 4 - bad, 4);
            wait_done(fd0);
            check(got.size() == 4, "R2", "literal length", got.size(), 4);
        end

        // R3: pad-only frame
        d = {};
        s = {8'h00, 8'h80, 8'h00, 8'h80};
        run_frame(d, s, "R3");

        // R1/R2 boundaries: 127 zeros then 127 literal bytes, no pads
        d = {};
        repeat (127) d.push_back(8'h00);
        for (int k = 0; k < 127; k++) d.push_back(8'(1 + k));
        s = encode(d, 1'b0);
        check(s.size() == 129, "R2", "max header stream size", s.size(), 129);
        run_frame(d, s, "R2");

        // R6: random frames with stalls, gaps and pads
        rnd_mode = 1'b1;
        for (int f = 0; f < 8; f++) begin
            d = rand_data();
            s = encode(d, 1'b1);
            run_frame(d, s, "R6");
        end
        rnd_mode = 1'b0;
        @(posedge clk); #1;
        check(!lit_error, "R8", "no error on clean frames", lit_error, 0);

        // R8: frame cut inside a literal block
        d = {8'h11, 8'h22};
        s = {8'h85, 8'h11, 8'h22};
        run_frame(d, s, "R8");
        check(lit_error, "R8", "error after cut literal", lit_error, 1);

        // R4/R8: next frame decodes normally, flag stays
        d = {8'h00, 8'h00, 8'h00, 8'h09, 8'h08};
        s = {8'h03, 8'h82, 8'h09, 8'h08};
        run_frame(d, s, "R4");
        check(lit_error, "R8", "error sticky", lit_error, 1);

        // R9/R8: reset clears, then last on a literal header
        rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!lit_error, "R9", "reset clears error", lit_error, 0);
        @(posedge clk); #1;
        d = {};
        s = {8'h83};
        run_frame(d, s, "R8");
        check(lit_error, "R8", "error on last literal header", lit_error, 1);

        finished = 1'b1;
        report();
    end
endmodule